// File: doc/BRIEF.md
# Serial Digital Potentiometer Command Controller

This block is the command side of a multi-wiper digital potentiometer. An SPI slave (mode 0) on a single system clock collects instruction frames. It holds one volatile wiper position per wiper and a bank of four save-backed data slots per wiper. A busy flag covers the time a save needs. The wiper positions leave the block on a flat bus for the analog side. The save timing is modelled with a cycle counter.

A frame opens when `cs_n` falls. The first byte is the instruction: bits [7:4] opcode, [3:2] wiper select, [1:0] slot index. There are three frame lengths. Long commands are three bytes: the instruction, a gap byte the block ignores, and a data byte. Short commands are two bytes: the instruction and a gap byte. The stepping command has no fixed length: after its instruction byte, every SCK rising edge moves the selected wiper one position. Writes take effect only when `cs_n` rises after a complete frame. Raising `cs_n` at any other point throws the frame away.

The controller is a state machine with seven states:
- IDLE: `cs_n` high.
- OPCODE: first eight bits.
- GAP: bits 9 to 16.
- PAYLOAD: bits 17 to 24.
- COMPLETE: frame finished.
- STEPPING: open-ended stepping.
- DISCARD: unknown opcode or overlong frame.

Its transitions are:
- IDLE→OPCODE when `cs_n` is seen low.
- OPCODE→GAP on the 8th bit of a long or short opcode.
- OPCODE→STEPPING on the 8th bit of the stepping opcode.
- OPCODE→DISCARD on the 8th bit of any other opcode.
- GAP→PAYLOAD on the 16th bit of a long command.
- GAP→COMPLETE on the 16th bit of a short command.
- PAYLOAD→COMPLETE on the 24th bit.
- COMPLETE→DISCARD on any further bit.
- Any state→IDLE when `cs_n` rises. This is the only place a committed action fires, and only from COMPLETE.

Top module: `dpot_ctrl`

## Requirements
- R1: After reset every wiper position is 0, every data slot is 0, `wip` is 0 and `so` is 0.
- R2: Opcode 0xA (write wiper) loads the data byte into the selected wiper at `cs_n` rise after a complete 24-bit frame, clamped to POS_MAX.
- R3: Read opcodes drive `so` MSB first on SCK falling edges during the third byte. 0x9 returns the selected wiper; 0x5 returns `wip` in bit 0 with bits 7..1 zero.
- R4: Opcode 0xC (write slot) stores the clamped data byte in slot [idx] of the selected wiper at `cs_n` rise. Opcode 0xB (read slot) returns it once the save is over.
- R5: `wip` rises the cycle after a save commits and stays high for T_NV cycles, then falls.
- R6: While `wip` is high, a save-type command is dropped and a slot read returns 0x00. A status read keeps working.
- R7: A frame cut short, or one with extra bits after its last byte, changes no register and starts no save.
- R8: Opcode 0xD (slot to wiper, 16 bits) loads slot [idx] into the selected wiper T_VOL cycles after `cs_n` rises, not before.
- R9: Opcode 0xE (wiper to slot, 16 bits) is a save. It copies the selected wiper into slot [idx] and raises `wip`.
- R10: Opcode 0x8 copies every wiper into its own slot [idx] as one save. Opcode 0x1 loads every wiper from its own slot [idx] after T_VOL cycles.
- R11: After instruction 0x2, each SCK rising edge moves the selected wiper up by one when SI is 1 and down by one when SI is 0.
- R12: Stepping stops at POS_MAX going up and at 0 going down, with no wraparound.
- R13: A `cs_n` rise in mid-frame returns the controller to IDLE with the bit count cleared, so the next frame decodes from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI lines are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in, sampled on SCK rise |
| so | output | 1 | Serial data out, changes on SCK fall, 0 when not reading |
| wiper_pos | output | NUM_WIPERS*POS_W | Wiper w position in bits [w*POS_W +: POS_W] |
| wip | output | 1 | Save in progress |

## Verification
The bench builds the block with four wipers and POS_MAX at 120. This makes the write clamp and the upper step limit reachable with 7-bit data. T_NV is set to 1000 cycles, long enough for a status read, a blocked slot read and a dropped slot write to fit inside one save, yet short enough to wait out. T_VOL is 12, so the wiper can be sampled once before and once after the delayed load.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int BYTE_W = 8;
    localparam int NUM_DR = 4;

    localparam logic [3:0] OP_GXFR_D2W = 4'h1;
    localparam logic [3:0] OP_STEP     = 4'h2;
    localparam logic [3:0] OP_RD_STAT  = 4'h5;
    localparam logic [3:0] OP_GXFR_W2D = 4'h8;
    localparam logic [3:0] OP_RD_WCR   = 4'h9;
    localparam logic [3:0] OP_WR_WCR   = 4'hA;
    localparam logic [3:0] OP_RD_DR    = 4'hB;
    localparam logic [3:0] OP_WR_DR    = 4'hC;
    localparam logic [3:0] OP_XFR_D2W  = 4'hD;
    localparam logic [3:0] OP_XFR_W2D  = 4'hE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_GAP,
        ST_PAYLOAD,
        ST_COMPLETE,
        ST_STEPPING,
        ST_DISCARD
    } state_e;

    function automatic logic op_long(input logic [3:0] op);
        return op inside {OP_RD_WCR, OP_WR_WCR, OP_RD_DR, OP_WR_DR, OP_RD_STAT};
    endfunction

    function automatic logic op_short(input logic [3:0] op);
        return op inside {OP_XFR_D2W, OP_XFR_W2D, OP_GXFR_D2W, OP_GXFR_W2D};
    endfunction

    function automatic logic op_save(input logic [3:0] op);
        return op inside {OP_WR_DR, OP_XFR_W2D, OP_GXFR_W2D};
    endfunction

endpackage

// File: rtl/dpot_spi_sync.sv
module dpot_spi_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic cs_hi,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    logic [2:0] cs_q;
    logic [2:0] sck_q;
    logic [1:0] si_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 3'b111;
            sck_q <= 3'b000;
            si_q  <= 2'b00;
        end else begin
            cs_q  <= {cs_q[1:0], cs_n};
            sck_q <= {sck_q[1:0], sck};
            si_q  <= {si_q[0], si};
        end
    end

    assign cs_hi    = cs_q[1];
    assign cs_rise  = cs_q[1] & ~cs_q[2];
    assign sck_rise = sck_q[1] & ~sck_q[2];
    assign sck_fall = ~sck_q[1] & sck_q[2];
    assign si_s     = si_q[1];

endmodule

// File: rtl/dpot_countdown.sv
module dpot_countdown #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == CW'(1));

    AST_LAST_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !busy); // R5

endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_pkg::*;
#(
    parameter int NUM_WIPERS = 4,
    parameter int POS_W      = 7,
    parameter int POS_MAX    = 127,
    parameter int T_NV       = 100000,
    parameter int T_VOL      = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        sck,
    input  logic                        si,
    output logic                        so,
    output logic [NUM_WIPERS*POS_W-1:0] wiper_pos,
    output logic                        wip
);
    localparam int CNT_W    = 5;
    localparam int BIT_OP   = BYTE_W - 1;
    localparam int BIT_GAP  = 2 * BYTE_W - 1;
    localparam int BIT_DATA = 3 * BYTE_W - 1;
    localparam int DR_BITS  = NUM_WIPERS * NUM_DR * POS_W;

    logic cs_hi, cs_rise, sck_rise, sck_fall, si_s;

    dpot_spi_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .si       (si),
        .cs_hi    (cs_hi),
        .cs_rise  (cs_rise),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s)
    );

    state_e              state_q, state_d;
    logic [CNT_W-1:0]    bit_cnt_q;
    logic [BYTE_W-1:0]   shin_q, instr_q, data_q, tx_q;
    logic [BYTE_W-1:0]   nxt_byte, rd_val;
    logic                bit_stb;
    logic [3:0]          op;
    logic [1:0]          sel, idx;
    logic                sel_ok;

    logic [POS_W-1:0]    wcr_q [NUM_WIPERS];
    logic [POS_W-1:0]    dr_q  [NUM_WIPERS][NUM_DR];
    logic [DR_BITS-1:0]  dr_flat;

    logic commit, nv_start, vol_start;
    logic nv_busy, nv_last, vol_busy, vol_last;
    logic pend_glob_q;
    logic [1:0] pend_sel_q, pend_idx_q;

    assign bit_stb  = sck_rise & ~cs_hi;
    assign nxt_byte = {shin_q[BYTE_W-2:0], si_s};
    assign op       = instr_q[7:4];
    assign sel      = instr_q[3:2];
    assign idx      = instr_q[1:0];
    assign sel_ok   = (int'(sel) < NUM_WIPERS);

    function automatic logic [POS_W-1:0] clamp(input logic [BYTE_W-1:0] v);
        if (int'(v) > POS_MAX) return POS_W'(POS_MAX);
        return v[POS_W-1:0];
    endfunction

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        if (cs_hi) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_OPCODE;
                ST_OPCODE:  if (bit_stb && bit_cnt_q == CNT_W'(BIT_OP)) begin
                                if (nxt_byte[7:4] == OP_STEP)                         state_d = ST_STEPPING;
                                else if (op_long(nxt_byte[7:4]) || op_short(nxt_byte[7:4])) state_d = ST_GAP;
                                else                                                  state_d = ST_DISCARD;
                            end
                ST_GAP:     if (bit_stb && bit_cnt_q == CNT_W'(BIT_GAP))
                                state_d = op_long(op) ? ST_PAYLOAD : ST_COMPLETE;
                ST_PAYLOAD: if (bit_stb && bit_cnt_q == CNT_W'(BIT_DATA)) state_d = ST_COMPLETE;
                ST_COMPLETE: if (bit_stb) state_d = ST_DISCARD;
                ST_STEPPING: state_d = ST_STEPPING;
                ST_DISCARD:  state_d = ST_DISCARD;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- frame capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shin_q    <= '0;
            instr_q   <= '0;
            data_q    <= '0;
        end else if (cs_hi) begin
            bit_cnt_q <= '0;
            shin_q    <= '0;
        end else if (bit_stb) begin
            if (bit_cnt_q != '1) bit_cnt_q <= bit_cnt_q + 1'b1;
            shin_q <= nxt_byte;
            if (bit_cnt_q == CNT_W'(BIT_OP))   instr_q <= nxt_byte;
            if (bit_cnt_q == CNT_W'(BIT_DATA)) data_q  <= nxt_byte;
        end
    end

    // ---------------- action decode ----------------
    assign commit    = cs_rise && (state_q == ST_COMPLETE);
    assign nv_start  = commit && op_save(op) && !nv_busy && (sel_ok || op == OP_GXFR_W2D);
    assign vol_start = commit && (op == OP_XFR_D2W || op == OP_GXFR_D2W);

    dpot_countdown #(.CYCLES(T_NV)) u_nv_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (nv_busy),
        .last  (nv_last)
    );

    dpot_countdown #(.CYCLES(T_VOL)) u_vol_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (vol_start),
        .busy  (vol_busy),
        .last  (vol_last)
    );

    // ---------------- register file ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WIPERS; w++) begin
                wcr_q[w] <= '0;
                for (int r = 0; r < NUM_DR; r++) dr_q[w][r] <= '0;
            end
            pend_glob_q <= 1'b0;
            pend_sel_q  <= '0;
            pend_idx_q  <= '0;
        end else begin
            if (vol_start) begin
                pend_glob_q <= (op == OP_GXFR_D2W);
                pend_sel_q  <= sel;
                pend_idx_q  <= idx;
            end
            if (commit && op == OP_WR_WCR && sel_ok) wcr_q[sel] <= clamp(data_q);
            if (bit_stb && state_q == ST_STEPPING && sel_ok) begin
                if (si_s && int'(wcr_q[sel]) < POS_MAX) wcr_q[sel] <= wcr_q[sel] + 1'b1;
                else if (!si_s && wcr_q[sel] != '0)     wcr_q[sel] <= wcr_q[sel] - 1'b1;
            end
            if (vol_last) begin
                for (int w = 0; w < NUM_WIPERS; w++)
                    if (pend_glob_q || int'(pend_sel_q) == w) wcr_q[w] <= dr_q[w][pend_idx_q];
            end
            if (nv_start) begin
                unique case (op)
                    OP_WR_DR:    dr_q[sel][idx] <= clamp(data_q);
                    OP_XFR_W2D:  dr_q[sel][idx] <= wcr_q[sel];
                    default:     for (int w = 0; w < NUM_WIPERS; w++) dr_q[w][idx] <= wcr_q[w];
                endcase
            end
        end
    end

    // ---------------- read data ----------------
    always_comb begin
        rd_val = '0;
        unique case (op)
            OP_RD_WCR:  if (sel_ok) rd_val = BYTE_W'(wcr_q[sel]);
            OP_RD_DR:   if (sel_ok && !nv_busy) rd_val = BYTE_W'(dr_q[sel][idx]);
            OP_RD_STAT: rd_val = {{(BYTE_W-1){1'b0}}, nv_busy};
            default:    rd_val = '0;
        endcase
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (state_q != ST_PAYLOAD) begin
            tx_q <= '0;
        end else if (sck_fall) begin
            if (bit_cnt_q == CNT_W'(BIT_GAP + 1)) tx_q <= rd_val;
            else                                  tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign so  = tx_q[BYTE_W-1];
    assign wip = nv_busy;

    for (genvar w = 0; w < NUM_WIPERS; w++) begin : g_out
        assign wiper_pos[w*POS_W +: POS_W] = wcr_q[w];
        for (genvar r = 0; r < NUM_DR; r++) begin : g_flat
            assign dr_flat[(w*NUM_DR + r)*POS_W +: POS_W] = dr_q[w][r];
        end
    end

    // ---------------- assertions ----------------
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (state_q == ST_IDLE)); // R13

    AST_SO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> !so); // R3

    AST_SAVE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> ($past(state_q) == ST_COMPLETE && $past(cs_rise))); // R7

    AST_SLOTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_rise && state_q == ST_COMPLETE) |=> $stable(dr_flat)); // R7

    AST_WIP_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_busy && !nv_last) |=> nv_busy); // R5

    AST_VOL_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vol_busy) |-> $past(cs_rise)); // R8

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEPPING && bit_stb && !vol_last) |=>
            (wcr_q[sel] == $past(wcr_q[sel]) ||
             wcr_q[sel] == $past(wcr_q[sel]) + 1'b1 ||
             wcr_q[sel] == $past(wcr_q[sel]) - 1'b1)); // R11

    AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wcr_q[sel]) <= POS_MAX); // R12

endmodule

// File: tb/test_dpot_ctrl.sv
module test_dpot_ctrl;
    localparam int NW    = 4;
    localparam int PW    = 7;
    localparam int PMAX  = 120;
    localparam int TNV   = 1000;
    localparam int TVOL  = 12;
    localparam int HALF  = 5;

    logic clk = 1'b0;
    logic rst_n, cs_n, sck, si;
    logic so, wip;
    logic [NW*PW-1:0] wiper_pos;

    int total = 0;
    int bad   = 0;

    byte unsigned exp_q[$];
    string        req_q[$];
    logic [7:0]   rx_byte;
    event         rx_ev;

    always #2.5 clk = ~clk;

    dpot_ctrl #(.NUM_WIPERS(NW), .POS_W(PW), .POS_MAX(PMAX), .T_NV(TNV), .T_VOL(TVOL)) i_dpot_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .si        (si),
        .so        (so),
        .wiper_pos (wiper_pos),
        .wip       (wip)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wpos(input int w);
        return int'(wiper_pos[w*PW +: PW]);
    endfunction

    // monitor: pops expected read bytes and compares
    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
            else chk(req_q.pop_front(), int'(rx_byte), int'(exp_q.pop_front()));
        end
    end

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [23:0] word, input int nbits, output logic [7:0] rx);
        rx = '0;
        cs_n = 1'b0;
        clocks(HALF);
        for (int i = 0; i < nbits; i++) begin
            si = (i < 24) ? word[23 - i] : 1'b0;
            clocks(HALF);
            if (i >= 16 && i < 24) rx = {rx[6:0], so};
            sck = 1'b1;
            clocks(HALF);
            sck = 1'b0;
        end
        clocks(HALF);
        cs_n = 1'b1;
    endtask

    task automatic frame(input logic [23:0] word, input int nbits);
        logic [7:0] rx;
        xfer(word, nbits, rx);
        clocks(2 * HALF);
    endtask

    task automatic rd(input logic [7:0] instr, input logic [7:0] exp, input string req);
        logic [7:0] rx;
        exp_q.push_back(exp);
        req_q.push_back(req);
        xfer({instr, 16'h0000}, 24, rx);
        rx_byte = rx;
        -> rx_ev;
        clocks(2 * HALF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] dummy;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
        clocks(5);
        rst_n = 1'b1;
        clocks(4);

        // R1 reset state
        for (int w = 0; w < NW; w++) chk("R1 wiper reset", wpos(w), 0);
        chk("R1 wip reset", int'(wip), 0);
        chk("R1 so reset", int'(so), 0);
        rd(8'hB5, 8'd0, "R1 slot reset");

        // R2 write wiper, R3 read back
        frame({8'hA0, 8'h00, 8'd50}, 24);
        chk("R2 write wiper0", wpos(0), 50);
        rd(8'h90, 8'd50, "R3 read wiper0");
        frame({8'hA4, 8'h00, 8'd127}, 24);
        chk("R2 clamp wiper1", wpos(1), PMAX);
        rd(8'h50, 8'd0, "R3 status idle");

        // R4/R5/R6 save and busy window
        frame({8'hC2, 8'h00, 8'd77}, 24);
        clocks(4);
        chk("R5 wip set after save", int'(wip), 1);
        rd(8'h50, 8'd1, "R5 status busy");
        rd(8'hB2, 8'd0, "R6 slot read blocked");
        frame({8'hC2, 8'h00, 8'd11}, 24);
        clocks(TNV);
        chk("R5 wip cleared", int'(wip), 0);
        rd(8'h50, 8'd0, "R5 status after save");
        rd(8'hB2, 8'd77, "R4 R6 slot holds first value");

        // R7 short and overlong frames
        frame({8'hA0, 8'h00, 8'd5}, 20);
        chk("R7 short frame no write", wpos(0), 50);
        frame({8'hC4, 8'h00, 8'd9}, 25);
        clocks(4);
        chk("R7 overlong no save", int'(wip), 0);
        rd(8'hB4, 8'd0, "R7 slot untouched");

        // R8 delayed slot-to-wiper load
        xfer({8'hD2, 8'h00, 8'h00}, 16, dummy);
        clocks(8);
        chk("R8 wiper before delay", wpos(0), 50);
        clocks(17);
        chk("R8 wiper after delay", wpos(0), 77);
        clocks(2 * HALF);

        // R9 wiper to slot save
        frame({8'hE7, 8'h00, 8'h00}, 16);
        chk("R9 wip raised", int'(wip), 1);
        clocks(TNV + 20);
        rd(8'hB7, 8'd120, "R9 slot got wiper1");

        // R10 global moves
        frame({8'hA8, 8'h00, 8'd30}, 24);
        frame({8'hAC, 8'h00, 8'd40}, 24);
        frame({8'h81, 8'h00, 8'h00}, 16);
        clocks(TNV + 20);
        frame({8'hA0, 8'h00, 8'd0}, 24);
        frame({8'hA4, 8'h00, 8'd0}, 24);
        frame({8'hA8, 8'h00, 8'd0}, 24);
        frame({8'hAC, 8'h00, 8'd0}, 24);
        xfer({8'h11, 8'h00, 8'h00}, 16, dummy);
        clocks(30);
        chk("R10 global load w0", wpos(0), 77);
        chk("R10 global load w1", wpos(1), 120);
        chk("R10 global load w2", wpos(2), 30);
        chk("R10 global load w3", wpos(3), 40);
        clocks(2 * HALF);

        // R11 stepping
        frame({8'h28, 16'b1110_0000_0000_0000}, 12);
        chk("R11 step up3 down1", wpos(2), 32);
        frame({8'h2C, 16'b0000_0000_0000_0000}, 13);
        chk("R11 step down5", wpos(3), 35);

        // R12 saturation
        frame({8'h24, 16'b1110_0000_0000_0000}, 11);
        chk("R12 top limit", wpos(1), PMAX);
        frame({8'hAC, 8'h00, 8'd1}, 24);
        frame({8'h2C, 16'h0000}, 11);
        chk("R12 bottom limit", wpos(3), 0);

        // R13 abort mid-frame, next frame decodes fresh
        frame({8'hA8, 8'h00, 8'h00}, 5);
        chk("R13 abort no change", wpos(2), 32);
        rd(8'h98, 8'd32, "R13 fresh decode");

        clocks(20);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule